// File: doc/BRIEF.md
# Sampling Converter Control Interface

This block is the digital control and bus logic that sits in front of a 12-bit sampling converter. It watches three asynchronous control lines: an active-low chip select, a read/convert line and a high-byte select. From them it decides when a hold-and-convert cycle starts. A down-counter of programmable length stands in for the analog conversion time. While that counter runs, a ready flag is held low. When the count ends, the block captures the word on a stub sample input into a result register.

The result is read back on a bus modelled as a 12-bit data vector plus an output-enable. The bus is driven only when the read/convert line is high, the chip is selected and no conversion is running. A strap input picks between a full-width word and two byte reads on an 8-bit bus. In the byte arrangement, the high-byte select steers which half appears. A falling read/convert edge starts a conversion only when the chip is selected, the high-byte select is low and the block is idle. Once a conversion runs, every control input is ignored until it completes.

Top module: `sadc_ctrl`

## Requirements
- R1: A conversion starts only when the synchronised read/convert line falls while chip select is low (selected), high-byte select is low and the block is idle. The ready flag goes low exactly 3 clock cycles after the falling input is applied: two synchroniser stages plus the state register.
- R2: No conversion starts if chip select is high or high-byte select is high when the read/convert line falls. A rising edge or a steady level on read/convert never starts one.
- R3: The ready flag stays low for exactly CONV_CYCLES clock cycles per conversion and is high at all other times.
- R4: While a conversion runs, the output enable is low. Changes on chip select, read/convert and high-byte select neither shorten nor restart it.
- R5: The output enable is high exactly when the synchronised read/convert line is high, the synchronised chip select is low and the ready flag is high.
- R6: With the byte strap set, a read with high-byte select low gives bits 7:0 of the result on data bits 7:0 and zeros above. A read with high-byte select high gives result bits 11:8 on data bits 3:0 and zeros on data bits 11:4.
- R7: With the byte strap clear, a read with high-byte select low gives the full 12-bit result. High-byte select high gives the same high-byte layout as R6.
- R8: The result register changes only at the end of a conversion, when it takes the sample input. A read made before a new conversion completes returns the previous result.
- R9: Whenever the output enable is low, the data vector is all zeros.
- R10: After reset the ready flag is high, the output enable is low and the result register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| chip_sel_n_i | input | 1 | Chip select, active low, asynchronous |
| rd_conv_i | input | 1 | Read/convert line; a qualified falling edge starts a conversion, high enables reading |
| hi_byte_i | input | 1 | High-byte select for byte reads; high also blocks a start |
| narrow_bus_i | input | 1 | Static strap: 1 selects byte reads, 0 selects full-word reads |
| sample_i | input | 12 | Stub converter result, captured at the end of a conversion |
| ready_o | output | 1 | High when idle, low during a conversion |
| dout_o | output | 12 | Data vector of the modelled three-state bus |
| dout_oe_o | output | 1 | Output enable of the modelled three-state bus |

## Verification
Several properties are checked on every cycle. The output enable never rises during a conversion, and a disabled bus always reads as zero. Every ready-low window lasts exactly the configured length, each start follows a qualified falling edge, the result register holds between conversions, and the byte layouts carry their zero fields. Other behaviour can only be shown by the bench scenarios, because it depends on the stimulus history. These are: the exact start latency, that an unselected edge or a high-byte-select edge starts nothing, that control activity during a conversion is ignored, that the captured value is the right one, and that a read before a new conversion ends returns the earlier result.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  localparam int RES_W  = 12;
  localparam int BYTE_W = 8;

  // Synchronised control lines; sel_n is active low.
  typedef struct packed {
    logic sel_n;
    logic rd;
    logic hi;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // Reset value of the synchronised lines: deselected, read/convert low,
  // high-byte select low, so no edge is seen on reset release.
  localparam ctl_t CTL_RST = '{sel_n: 1'b1, rd: 1'b0, hi: 1'b0};

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } seq_st_t;

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_n_i,
  input  sadc_pkg::ctl_t d_i,
  output sadc_pkg::ctl_t q_o
);
  import sadc_pkg::*;

  ctl_t stg_q [STAGES];
  ctl_t stg_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb stg_d[g] = d_i;
    end else begin : g_next
      always_comb stg_d[g] = stg_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) stg_q[g] <= CTL_RST;
      else          stg_q[g] <= stg_d[g];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq #(
  parameter int CONV_CYCLES = 24
) (
  input  logic                       clk_i,
  input  logic                       rst_n_i,
  input  sadc_pkg::ctl_t             ctl_i,
  input  logic [sadc_pkg::RES_W-1:0] sample_i,
  output logic                       ready_o,
  output logic [sadc_pkg::RES_W-1:0] result_o
);
  import sadc_pkg::*;

  localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(CONV_CYCLES - 1);

  seq_st_t          st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [RES_W-1:0] res_q;
  logic             res_en;
  logic             rd_prev_q;
  logic             start;

  // Qualified falling edge of read/convert, accepted only when idle.
  assign start = rd_prev_q & ~ctl_i.rd & ~ctl_i.sel_n & ~ctl_i.hi
               & (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    res_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_CONV;
          cnt_d = CNT_LOAD;
        end
      end
      ST_CONV: begin
        if (cnt_q == '0) begin
          st_d   = ST_IDLE;
          res_en = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      rd_prev_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      rd_prev_q <= ctl_i.rd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    res_q <= '0;
    else if (res_en) res_q <= sample_i;
  end

  assign ready_o  = (st_q == ST_IDLE);
  assign result_o = res_q;

endmodule

// File: rtl/sadc_outmux.sv
module sadc_outmux (
  input  sadc_pkg::ctl_t             ctl_i,
  input  logic                       ready_i,
  input  logic                       narrow_i,
  input  logic [sadc_pkg::RES_W-1:0] result_i,
  output logic [sadc_pkg::RES_W-1:0] dout_o,
  output logic                       oe_o
);
  import sadc_pkg::*;

  localparam int HI_W = RES_W - BYTE_W;

  logic [RES_W-1:0] sel_word;

  always_comb begin
    oe_o = ctl_i.rd & ~ctl_i.sel_n & ready_i;
    if (ctl_i.hi)
      sel_word = {{(RES_W-HI_W){1'b0}}, result_i[RES_W-1:BYTE_W]};
    else if (narrow_i)
      sel_word = {{HI_W{1'b0}}, result_i[BYTE_W-1:0]};
    else
      sel_word = result_i;
    dout_o = oe_o ? sel_word : '0;
  end

endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl #(
  parameter int CONV_CYCLES = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_n_i,
  input  logic                       chip_sel_n_i,
  input  logic                       rd_conv_i,
  input  logic                       hi_byte_i,
  input  logic                       narrow_bus_i,
  input  logic [sadc_pkg::RES_W-1:0] sample_i,
  output logic                       ready_o,
  output logic [sadc_pkg::RES_W-1:0] dout_o,
  output logic                       dout_oe_o
);
  import sadc_pkg::*;

  ctl_t             ctl_raw;
  ctl_t             ctl_s;
  logic [RES_W-1:0] result_q;
  logic             ready;

  assign ctl_raw = '{sel_n: chip_sel_n_i, rd: rd_conv_i, hi: hi_byte_i};

  sadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .d_i     (ctl_raw),
    .q_o     (ctl_s)
  );

  sadc_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .ctl_i    (ctl_s),
    .sample_i (sample_i),
    .ready_o  (ready),
    .result_o (result_q)
  );

  sadc_outmux u_mux (
    .ctl_i    (ctl_s),
    .ready_i  (ready),
    .narrow_i (narrow_bus_i),
    .result_i (result_q),
    .dout_o   (dout_o),
    .oe_o     (dout_oe_o)
  );

  assign ready_o = ready;

endmodule

// File: rtl/sadc_ctrl_chk.sv
module sadc_ctrl_chk #(
  parameter int CONV_CYCLES = 24
) (
  input logic                       clk_i,
  input logic                       rst_n_i,
  input sadc_pkg::ctl_t             ctl_s,
  input logic                       narrow_bus_i,
  input logic                       ready_o,
  input logic                       dout_oe_o,
  input logic [sadc_pkg::RES_W-1:0] dout_o,
  input logic [sadc_pkg::RES_W-1:0] result_q
);
  import sadc_pkg::*;

  logic        rd_seen_q;
  logic [31:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rd_seen_q <= 1'b0;
      low_cnt_q <= '0;
    end else begin
      rd_seen_q <= ctl_s.rd;
      low_cnt_q <= ready_o ? 32'd0 : low_cnt_q + 32'd1;
    end
  end

  // R1: every start follows a qualified falling edge
  p_start_qualified_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(ready_o) |-> $past(rd_seen_q && !ctl_s.rd && !ctl_s.sel_n && !ctl_s.hi));

  // R3: ready-low window never exceeds the configured length
  p_busy_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !ready_o |-> (low_cnt_q < CONV_CYCLES));

  // R3: each window ends after exactly the configured length
  p_busy_exact_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(ready_o) |-> (low_cnt_q == CONV_CYCLES));

  // R4: bus stays disabled during a conversion
  p_oe_idle_only_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    dout_oe_o |-> ready_o);

  // R5: enable requires read high and chip selected
  p_oe_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    dout_oe_o |-> (ctl_s.rd && !ctl_s.sel_n));

  // R6: high-byte read leaves upper data bits zero
  p_hi_layout_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (dout_oe_o && ctl_s.hi) |-> (dout_o[RES_W-1:4] == '0));

  // R6: low-byte read in byte mode leaves the top nibble zero
  p_lo_layout_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (dout_oe_o && !ctl_s.hi && narrow_bus_i) |-> (dout_o[RES_W-1:BYTE_W] == '0));

  // R8: result holds while no conversion ends
  p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ready_o && $past(ready_o)) |-> $stable(result_q));

  // R9: disabled bus reads as zero
  p_zero_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !dout_oe_o |-> (dout_o == '0));

endmodule

bind sadc_ctrl sadc_ctrl_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .rst_n_i      (rst_n_i),
  .ctl_s        (ctl_s),
  .narrow_bus_i (narrow_bus_i),
  .ready_o      (ready_o),
  .dout_oe_o    (dout_oe_o),
  .dout_o       (dout_o),
  .result_q     (result_q)
);

// File: tb/test_sadc_ctrl.sv
module test_sadc_ctrl;

  localparam int CONV = 10;
  localparam int W    = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sel_n, rd, hi, narrow;
  logic [W-1:0] sample;
  logic         ready, oe;
  logic [W-1:0] dout;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  sadc_ctrl #(.CONV_CYCLES(CONV), .SYNC_STAGES(2)) i_sadc_ctrl (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .chip_sel_n_i (sel_n),
    .rd_conv_i    (rd),
    .hi_byte_i    (hi),
    .narrow_bus_i (narrow),
    .sample_i     (sample),
    .ready_o      (ready),
    .dout_o       (dout),
    .dout_oe_o    (oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] exp_word(input logic [W-1:0] r, input logic nb, input logic h);
    if (h)       return {8'h00, r[11:8]};
    else if (nb) return {4'h0, r[7:0]};
    else         return r;
  endfunction

  // Falling edge on read/convert with a measured ready-low window.
  task automatic convert(input string req, output int low_len);
    rd = 1'b0;
    wait_n(2);
    check({req, " R1 no early start"}, ready, 1'b1);
    wait_n(1);
    check({req, " R1 ready low after 3 cycles"}, ready, 1'b0);
    low_len = 1;
    for (int i = 0; i < 4 * CONV; i++) begin
      @(negedge clk);
      if (ready) break;
      low_len++;
    end
  endtask

  task automatic read_check(input string req, input logic h, input logic [W-1:0] r);
    hi = h;
    rd = 1'b1;
    wait_n(3);
    check({req, " oe"}, oe, 1'b1);
    check({req, " data"}, dout, exp_word(r, narrow, h));
  endtask

  task automatic t_reset();
    check("R10 ready after reset", ready, 1'b1);
    check("R10 oe after reset", oe, 1'b0);
    check("R9 bus zero after reset", dout, '0);
    sel_n = 1'b0;
    rd    = 1'b1;
    wait_n(3);
    check("R10 result zero oe", oe, 1'b1);
    check("R10 result zero data", dout, '0);
  endtask

  task automatic t_convert_mode();
    int len;
    narrow = 1'b0;
    sample = 12'hA5C;
    convert("R3 convert", len);
    check("R3 busy length", len, CONV);
    check("R4 oe after busy while rd low", oe, 1'b0);
    read_check("R7 full word", 1'b0, 12'hA5C);
  endtask

  task automatic t_lockout();
    int len;
    bit oe_seen;
    sample = 12'h3E7;
    rd = 1'b0;
    wait_n(3);
    check("R4 started", ready, 1'b0);
    oe_seen = 1'b0;
    len = 1;
    sel_n = 1'b1; @(negedge clk); if (oe) oe_seen = 1'b1; if (!ready) len++;
    rd = 1'b1;    @(negedge clk); if (oe) oe_seen = 1'b1; if (!ready) len++;
    sel_n = 1'b0; @(negedge clk); if (oe) oe_seen = 1'b1; if (!ready) len++;
    hi = 1'b1;    @(negedge clk); if (oe) oe_seen = 1'b1; if (!ready) len++;
    hi = 1'b0;    @(negedge clk); if (oe) oe_seen = 1'b1; if (!ready) len++;
    rd = 1'b0;    @(negedge clk); if (oe) oe_seen = 1'b1; if (!ready) len++;
    rd = 1'b1;
    for (int i = 0; i < 4 * CONV; i++) begin
      @(negedge clk);
      if (oe && !ready) oe_seen = 1'b1;
      if (ready) break;
      len++;
    end
    check("R4 no restart length", len, CONV);
    check("R4 oe stayed low during busy", oe_seen, 1'b0);
    wait_n(3);
    check("R4 no extra start", ready, 1'b1);
    read_check("R7 lockout result", 1'b0, 12'h3E7);
  endtask

  task automatic t_inhibit();
    sample = 12'h111;
    sel_n = 1'b1;
    rd    = 1'b1;
    wait_n(3);
    check("R5 deselected oe", oe, 1'b0);
    check("R9 deselected data", dout, '0);
    rd = 1'b0;
    wait_n(6);
    check("R2 no start when deselected", ready, 1'b1);
    rd = 1'b1;
    wait_n(3);
    sel_n = 1'b0;
    hi    = 1'b1;
    wait_n(3);
    rd = 1'b0;
    wait_n(6);
    check("R2 no start with hi select", ready, 1'b1);
    rd = 1'b1;
    wait_n(6);
    check("R2 rising edge no start", ready, 1'b1);
    hi = 1'b0;
    read_check("R2 result unchanged", 1'b0, 12'h3E7);
  endtask

  task automatic t_bytes();
    int len;
    narrow = 1'b1;
    sample = 12'hC96;
    rd = 1'b1;
    wait_n(3);
    convert("R6 byte", len);
    check("R3 byte busy length", len, CONV);
    read_check("R6 low byte", 1'b0, 12'hC96);
    read_check("R6 high byte", 1'b1, 12'hC96);
    narrow = 1'b0;
    read_check("R7 high byte wide", 1'b1, 12'hC96);
    hi = 1'b0;
    rd = 1'b0;
    wait_n(CONV + 5);
    check("R5 rd low oe", oe, 1'b0);
  endtask

  task automatic t_read_mode();
    int len;
    narrow = 1'b0;
    rd = 1'b1;
    wait_n(3);
    sample = 12'h05A;
    wait_n(2);
    read_check("R8 previous result", 1'b0, 12'hC96);
    convert("R8 read mode", len);
    check("R3 read mode length", len, CONV);
    read_check("R8 new result", 1'b0, 12'h05A);
  endtask

  initial begin
    rst_n  = 1'b0;
    sel_n  = 1'b1;
    rd     = 1'b1;
    hi     = 1'b0;
    narrow = 1'b0;
    sample = '0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_convert_mode();
    t_lockout();
    t_inhibit();
    t_bytes();
    t_read_mode();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule